// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory whose data bus never idles when traffic switches between reads and writes. Every control input is registered on the rising clock edge. A write presents its address and lane enables in one cycle and its data two active cycles later. A read returns its data on the output register two active edges after its address was taken. Because both delays are the same, a read and a write each take exactly one data-bus slot, and any mix of them can run back to back.

A write whose data has arrived is held in a one-entry commit buffer and goes into the array on the next active edge. A read that reaches the output stage while that commit is still pending takes the newest bytes from the buffer. The merge is lane by lane, so the result matches a memory that applied every write in issue order. A cycle-start input either loads a new cycle type (read, write or deselect) or continues the previous type at the address the external burst sequencer presents. An active-low clock enable freezes the whole pipeline. An asynchronous output enable gates only the bus-drive indication.

The control path is a three-state machine whose state is the type of the cycle taken at the last active edge. The states are IDLE (deselect), READ and WRITE. Four transitions apply: LOAD_READ, LOAD_WRITE and LOAD_DESEL when cycle start is low, and ADVANCE when it is high, which keeps the current state.

Top module: `lt_sram_core`

## Requirements
- R1: While reset is asserted and right after it, `rdata_vld` and `bus_drive` are 0 and the state machine is in IDLE.
- R2: A read taken at active edge N puts the word stored at its address on `rdata`, with `rdata_vld` high, right after active edge N+2. After any active edge that completes no read, `rdata_vld` is 0.
- R3: A write taken at active edge N samples its lane enables `lane_we_n` at edge N (bit i low enables bits [8i+7:8i]) and its data `wdata` at active edge N+2. Only the enabled lanes of the word change.
- R4: A load cycle is selected only when `cs_n`=0, `cs_hi`=1 and `cs2_n`=0. Any other combination is a deselect, which writes nothing and returns no data.
- R5: With `ld_n`=1 the previous cycle type (read, write or deselect) continues at the address now on `addr`. The chip enables and `rd_nwr` are ignored in that case.
- R6: With `clk_en_n`=1 the clock edge is ignored. The pipeline, the pending commit, the array and the outputs hold, and the edge is not counted as one of the N+2 edges.
- R7: A read returns the bytes of every write issued before it, even when that write's data has not yet reached the array. The merge is per lane: pending enabled lanes are taken from the commit buffer and the rest from the array.
- R8: `bus_drive` equals `rdata_vld` gated by `oe_n`=0, combinationally. `oe_n` does not change `rdata`.
- R9: Reads and writes alternating on every active edge, to the same address, each complete in their own slot with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the edge |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| cs2_n | input | 1 | Second active-low chip select |
| ld_n | input | 1 | Low: load a new cycle type; high: advance the previous type |
| rd_nwr | input | 1 | 1 = read, 0 = write, sampled on load cycles |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| wdata | input | LANES*LANE_W | Write data, sampled two active edges after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_vld | output | 1 | Registered: rdata holds a completed read |
| bus_drive | output | 1 | The data bus is being driven by the block |

## Verification
The two functions that can act in the same cycle are the array commit of a write and the output-stage read of the same word. A write taken one active edge before a read to the same address still has its bytes in the commit buffer when the read is loaded onto the output register. Directed alternating write/read pairs to one address provoke this every slot. Random traffic over a small address window, with partial lane enables and clock-enable stalls, provokes it again. Each returned word is judged against a reference memory that the bench updates in issue order, so a stale lane shows up as a miscompare.

// File: rtl/lt_sram_pkg.sv
package lt_sram_pkg;
    // Cycle type held in each pipeline stage
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/lt_sram_ctrl.sv
module lt_sram_ctrl
    import lt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld_n,
    input  logic              sel,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    output cyc_e              s2_typ,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_be
);
    // State = type of cycle taken at the last active edge (stage 1)
    cyc_e              cur_st;
    cyc_e              nxt_st;
    cyc_e              load_typ;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;

    always_comb begin
        if (!sel)        load_typ = CYC_IDLE;   // LOAD_DESEL
        else if (rd_nwr) load_typ = CYC_READ;   // LOAD_READ
        else             load_typ = CYC_WRITE;  // LOAD_WRITE
    end

    // Next-state: ADVANCE keeps the state, a load takes the decoded type
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            CYC_IDLE:  if (!ld_n) nxt_st = load_typ;
            CYC_READ:  if (!ld_n) nxt_st = load_typ;
            CYC_WRITE: if (!ld_n) nxt_st = load_typ;
            default:   nxt_st = CYC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cur_st <= CYC_IDLE;
        else if (en) cur_st <= nxt_st;
    end

    // Stage registers: address and lane enables follow the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_addr <= '0;
            s1_be   <= '0;
            s2_typ  <= CYC_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (en) begin
            s1_addr <= addr;
            s1_be   <= ~lane_we_n;
            s2_typ  <= cur_st;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end
endmodule

// File: rtl/lt_sram_wbuf.sv
module lt_sram_wbuf
    import lt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  cyc_e              s2_typ,
    input  logic [ADDR_W-1:0] s2_addr,
    input  logic [LANES-1:0]  s2_be,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     arr_q,
    output logic              cm_vld,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [LANES-1:0]  cm_be,
    output logic [DW-1:0]     cm_data,
    output logic [DW-1:0]     fwd_q
);
    logic hit;

    // Data arrives while its write sits in stage 2: capture for commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_vld  <= 1'b0;
            cm_addr <= '0;
            cm_be   <= '0;
            cm_data <= '0;
        end else if (en) begin
            cm_vld  <= (s2_typ == CYC_WRITE);
            cm_addr <= s2_addr;
            cm_be   <= s2_be;
            cm_data <= wdata;
        end
    end

    assign hit = cm_vld && (cm_addr == rd_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_merge
        assign fwd_q[i*LANE_W +: LANE_W] = (hit && cm_be[i]) ? cm_data[i*LANE_W +: LANE_W]
                                                             : arr_q[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lt_sram_array.sv
module lt_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (en && we && wbe[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
        end

        assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/lt_sram_core.sv
module lt_sram_core
    import lt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              cs_n,
    input  logic              cs_hi,
    input  logic              cs2_n,
    input  logic              ld_n,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [DW-1:0]     wdata,
    input  logic              oe_n,
    output logic [DW-1:0]     rdata,
    output logic              rdata_vld,
    output logic              bus_drive
);
    logic              en;
    logic              sel;
    cyc_e              s2_typ;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;
    logic              cm_vld;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_be;
    logic [DW-1:0]     cm_data;
    logic [DW-1:0]     arr_q;
    logic [DW-1:0]     fwd_q;

    assign en  = ~clk_en_n;
    assign sel = ~cs_n & cs_hi & ~cs2_n;

    lt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .sel(sel),
        .rd_nwr(rd_nwr), .addr(addr), .lane_we_n(lane_we_n),
        .s2_typ(s2_typ), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    lt_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .en(en), .s2_typ(s2_typ), .s2_addr(s2_addr),
        .s2_be(s2_be), .wdata(wdata), .rd_addr(s2_addr), .arr_q(arr_q),
        .cm_vld(cm_vld), .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data),
        .fwd_q(fwd_q)
    );

    lt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .en(en), .we(cm_vld), .waddr(cm_addr), .wbe(cm_be),
        .wdata(cm_data), .raddr(s2_addr), .rdata(arr_q)
    );

    // Output register: read data lands two active edges after its address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_vld <= 1'b0;
            rdata     <= '0;
        end else if (en) begin
            rdata_vld <= (s2_typ == CYC_READ);
            if (s2_typ == CYC_READ) rdata <= fwd_q;
        end
    end

    assign bus_drive = rdata_vld & ~oe_n;
endmodule

// File: rtl/lt_sram_core_chk.sv
module lt_sram_core_chk
    import lt_sram_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          cs_n,
    input logic          cs_hi,
    input logic          cs2_n,
    input logic          ld_n,
    input logic          oe_n,
    input logic [DW-1:0] rdata,
    input logic          rdata_vld,
    input logic          bus_drive,
    input cyc_e          s1_typ,
    input cyc_e          s2_typ
);
    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s2_typ == CYC_READ) |=> rdata_vld); // R2
    AST_NONREAD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s2_typ != CYC_READ) |=> !rdata_vld); // R2
    AST_DESELECT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !ld_n && (cs_n || !cs_hi || cs2_n)) |=> (s1_typ == CYC_IDLE)); // R4
    AST_ADVANCE_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && ld_n) |=> (s1_typ == $past(s1_typ))); // R5
    AST_STALL_FREEZES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(rdata_vld) && $stable(rdata))); // R6
    AST_STALL_FREEZES_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(s1_typ) && $stable(s2_typ))); // R6
    AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_drive); // R8
endmodule

bind lt_sram_core lt_sram_core_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_n(cs_n), .cs_hi(cs_hi),
    .cs2_n(cs2_n), .ld_n(ld_n), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld),
    .bus_drive(bus_drive), .s1_typ(u_ctrl.cur_st), .s2_typ(s2_typ)
);

// File: tb/lt_sram_core_tb.sv
`timescale 1ns/1ps
module lt_sram_core_tb;
    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int T_IDLE = 0, T_RD = 1, T_WR = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en_n = 1'b0;
    logic              cs_n = 1'b1, cs_hi = 1'b1, cs2_n = 1'b0;
    logic              ld_n = 1'b0, rd_nwr = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [LANES-1:0]  lane_we_n = '1;
    logic [DW-1:0]     wdata = '0;
    logic              oe_n = 1'b0;
    logic [DW-1:0]     rdata;
    logic              rdata_vld, bus_drive;

    lt_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_n(cs_n), .cs_hi(cs_hi),
        .cs2_n(cs2_n), .ld_n(ld_n), .rd_nwr(rd_nwr), .addr(addr), .lane_we_n(lane_we_n),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld), .bus_drive(bus_drive)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, done = 0, rd_seen = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_part [DEPTH];
    // history: [0] issued at last active edge, [2] two before that
    int            h_typ [3];
    logic [DW-1:0] h_d   [3];
    logic [ADDR_W-1:0] h_a [3];
    int            h_fl  [3];   // bit0 advance, bit1 forward, bit2 partial, bit3 deselect, bit4 alternating phase
    int            last_typ = T_IDLE;
    bit            prev_stall = 0;
    int            phase_fl = 0;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LANES-1:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < LANES; i++) if (be[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic string tags(int fl, bit st);
        string s = "R2";
        if (fl[0]) s = {s, " R5"};
        if (fl[1]) s = {s, " R7"};
        if (fl[2]) s = {s, " R3"};
        if (fl[3]) s = {s, " R4"};
        if (fl[4]) s = {s, " R9"};
        if (st)    s = {s, " R6"};
        return s;
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus slot: check outputs of the previous edge, drive, clock, update model
    task automatic slot(bit stall, bit adv, int desel, bit rd, logic [ADDR_W-1:0] a,
                        logic [LANES-1:0] be_n, bit oe);
        int typ;
        @(negedge clk);
        chk(rdata_vld == (h_typ[2] == T_RD), tags(h_fl[2], prev_stall),
            DW'(rdata_vld), DW'(h_typ[2] == T_RD));
        if (h_typ[2] == T_RD) begin
            chk(rdata == h_d[2], tags(h_fl[2], prev_stall), rdata, h_d[2]);
            if (h_fl[2][4] && rdata_vld) rd_seen++;
        end
        clk_en_n  = stall;
        ld_n      = adv;
        cs_n      = (desel == 1);
        cs_hi     = (desel != 2);
        cs2_n     = (desel == 3);
        rd_nwr    = rd;
        addr      = a;
        lane_we_n = be_n;
        oe_n      = oe;
        wdata     = (h_typ[1] == T_WR) ? h_d[1] : DW'($urandom);
        #1;
        chk(bus_drive == (rdata_vld && !oe), "R8", DW'(bus_drive), DW'(rdata_vld && !oe));
        @(posedge clk);
        prev_stall = stall;
        if (!stall) begin
            typ = adv ? last_typ : (desel != 0 ? T_IDLE : (rd ? T_RD : T_WR));
            last_typ = typ;
            for (int k = 2; k > 0; k--) begin
                h_typ[k] = h_typ[k-1]; h_d[k] = h_d[k-1]; h_a[k] = h_a[k-1]; h_fl[k] = h_fl[k-1];
            end
            h_typ[0] = typ;
            h_a[0]   = a;
            h_fl[0]  = phase_fl | (adv ? 1 : 0) | ((!adv && desel != 0) ? 8 : 0);
            if (typ == T_WR) begin
                h_d[0] = DW'($urandom);
                ref_mem[a]  = merge(ref_mem[a], h_d[0], ~be_n);
                ref_part[a] = (be_n != '0);
            end else if (typ == T_RD) begin
                h_d[0] = ref_mem[a];
                if (h_typ[1] == T_WR && h_a[1] == a) h_fl[0] |= 2;
                if (ref_part[a]) h_fl[0] |= 4;
            end else begin
                h_d[0] = '0;
            end
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin h_typ[k] = T_IDLE; h_d[k] = '0; h_a[k] = '0; h_fl[k] = 0; end
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rdata_vld == 1'b0, "R1", DW'(rdata_vld), 0);
        chk(bus_drive == 1'b0, "R1", DW'(bus_drive), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata_vld == 1'b0 && bus_drive == 1'b0, "R1", DW'(rdata_vld), 0);
        // fill every word with a full-lane write
        for (int a = 0; a < DEPTH; a++) slot(0, 0, 0, 0, ADDR_W'(a), '0, 0);
        // alternating write/read to one address, no idle slot
        phase_fl = 16;
        for (int k = 0; k < 16; k++) begin
            slot(0, 0, 0, 0, 6'd5, LANES'($urandom), 0);
            slot(0, 0, 0, 1, 6'd5, '1, 0);
        end
        phase_fl = 0;
        // advance: read continued at new addresses, write continued, deselect continued
        slot(0, 0, 0, 1, 6'd10, '1, 0);
        for (int k = 1; k < 4; k++) slot(0, 1, 2, 0, ADDR_W'(10 + k), '1, 0);
        slot(0, 0, 0, 0, 6'd20, 4'b1010, 0);
        for (int k = 1; k < 4; k++) slot(0, 1, 1, 1, ADDR_W'(20 + k), 4'b0110, 0);
        // each chip enable alone deselects, then advancing a deselect stays idle
        for (int d = 1; d <= 3; d++) slot(0, 0, d, 0, 6'd7, '0, 0);
        slot(0, 1, 0, 0, 6'd7, '0, 0);
        for (int a = 7; a < 24; a++) slot(0, 0, 0, 1, ADDR_W'(a), '1, 0);
        // random traffic with stalls
        for (int k = 0; k < 3000; k++) begin
            int r_desel = ($urandom % 8 == 0) ? 1 + int'($urandom % 3) : 0;
            logic [LANES-1:0] r_be = ($urandom % 3 == 0) ? '0 : LANES'($urandom);
            slot($urandom % 6 == 0, $urandom % 4 == 0, r_desel, $urandom % 2 == 1,
                 ADDR_W'($urandom % 8), r_be, $urandom % 5 == 0);
        end
        repeat (4) slot(0, 0, 1, 1, '0, '1, 0);
        chk(rd_seen == 16, "R9", DW'(rd_seen), 16);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule